// File: doc/BRIEF.md
# Token-Driven Column Data Loader

This block spreads a serial stream of 6-bit gray-level words over a row of column registers without an address counter. A single token enters the chain at one end. It walks from channel to channel, and wherever it sits, the word currently on the data bus is written into that channel's temporary register. A level-sensitive latch control then moves the whole temporary row into the output row in one step, or keeps the output row frozen while the next row is being loaded.

The shift direction can be selected. In the narrow mode the four channels at each end of the row are bypassed. When a load completes, a one-cycle token is sent out of the far end so that several loaders can be chained into one longer row. Internally the token advances at half the shift-clock rate and writes two channels per step. The external rate stays at one word per shift-clock edge.

Top module: `col_token_loader`

## Requirements
- R1: While `rstN` is low, and after it is released, `colData` is all zero and both token outputs are low.
- R2: With `dirRight`=1 and `fullWidth`=1, a token sampled high on `lowEndTokIn` at edge e0 causes word k (k = 0 to NUM_CH-1), sampled from `dataIn` at edge e0+2+k, to land in channel k. Channel c occupies `colData[c*6 +: 6]`. Bus values at edges outside that window are not stored.
- R3: With `dirRight`=0 and `fullWidth`=1, the token is taken from `highEndTokIn`, and word k lands in channel NUM_CH-1-k.
- R4: With `dirRight`=1 and `fullWidth`=0, word k lands in channel 4+k, for NUM_CH-8 words. Channels 0 to 3 and NUM_CH-4 to NUM_CH-1 keep their previous contents.
- R5: With `dirRight`=0 and `fullWidth`=0, word k lands in channel NUM_CH-5-k. The same eight edge channels keep their previous contents.
- R6: For a load of M words started at edge e0, the token output at the far end (`highEndTokOut` when shifting right, `lowEndTokOut` when shifting left) is high for exactly one cycle. It becomes visible after edge e0+M-1, so a chained loader samples it at edge e0+M and takes its first word on the edge after this loader's last word.
- R7: The token output at the entry end stays low for the whole load.
- R8: While `latHold` is low, `colData` follows the temporary registers, including every word written at the most recent edge.
- R9: While `latHold` is high, `colData` does not change, even if a load runs meanwhile.
- R10: A token arriving before a load has finished restarts the load from the first channel. Only the restarted load produces a token output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low master reset |
| dirRight | input | 1 | 1: load from low channel upward; 0: from high channel downward |
| fullWidth | input | 1 | 1: all channels; 0: bypass four channels at each end |
| lowEndTokIn | input | 1 | Token input when shifting right |
| highEndTokIn | input | 1 | Token input when shifting left |
| dataIn | input | DW | Gray-level word stream |
| latHold | input | 1 | 0: output row transparent; 1: output row held |
| lowEndTokOut | output | 1 | Cascade token output when shifting left |
| highEndTokOut | output | 1 | Cascade token output when shifting right |
| colData | output | NUM_CH*DW | Output row, channel c at bits c*DW +: DW |

## Verification
A token that is lost, duplicated or misplaced inside the chain shows up at `colData`. The expected words land in shifted or repeated channels, and this is visible within one edge of the faulty write whenever the latch is transparent. The same fault shifts or suppresses the far-end token pulse, which can be seen within a single cycle of its expected position. A wrong pairing between the staged word and the live word swaps neighbouring channels. This is caught when the row is compared after the load.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  typedef struct packed {
    logic stageEn;  // capture the even word of a pair
    logic pairWr;   // write staged word and live word into the selected pair
  } loadStrobe_t;
endpackage

// File: rtl/col_loader_ctrl.sv
module col_loader_ctrl
  import col_loader_pkg::*;
#(
  parameter int NUM_CH = 200,
  parameter int EDGE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRight,
  input  logic              fullWidth,
  input  logic              lowEndTokIn,
  input  logic              highEndTokIn,
  output loadStrobe_t       strobe,
  output logic [NUM_CH/2-1:0] pairSel,
  output logic              lowEndTokOut,
  output logic              highEndTokOut
);
  localparam int NP = NUM_CH / 2;
  localparam int PW = $clog2(NP);
  localparam int SKIP_PAIRS = EDGE / 2;

  logic          tokInSel, seen1, seen2, phaseB, tokOutQ;
  logic [NP-1:0] tokQ, tokShift, startVec;
  logic [PW-1:0] firstPair, lastPair;

  assign tokInSel  = dirRight ? lowEndTokIn : highEndTokIn;
  assign firstPair = fullWidth ? PW'(0) : PW'(SKIP_PAIRS);
  assign lastPair  = fullWidth ? PW'(NP - 1) : PW'(NP - 1 - SKIP_PAIRS);

  always_comb begin
    for (int j = 0; j < NP; j++) begin
      startVec[j] = (PW'(j) == firstPair);
      if (j == 0) tokShift[j] = 1'b0;
      else        tokShift[j] = tokQ[j-1] && (PW'(j - 1) != lastPair);
    end
  end

  assign strobe.stageEn = seen2 || ((|tokQ) && !phaseB);
  assign strobe.pairWr  = !seen2 && phaseB;
  assign pairSel        = tokQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen1   <= 1'b0;
      seen2   <= 1'b0;
      phaseB  <= 1'b0;
      tokQ    <= '0;
      tokOutQ <= 1'b0;
    end else begin
      seen1   <= tokInSel;
      seen2   <= seen1;
      tokOutQ <= strobe.pairWr && tokQ[lastPair - PW'(1)];
      if (seen2) begin
        tokQ   <= startVec;
        phaseB <= 1'b1;
      end else if (|tokQ) begin
        if (phaseB) begin
          tokQ   <= tokShift;
          phaseB <= 1'b0;
        end else begin
          phaseB <= 1'b1;
        end
      end
    end
  end

  assign lowEndTokOut  = !dirRight && tokOutQ;
  assign highEndTokOut = dirRight && tokOutQ;
endmodule

// File: rtl/col_loader_datapath.sv
module col_loader_datapath
  import col_loader_pkg::*;
#(
  parameter int NUM_CH = 200,
  parameter int DW     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dirRight,
  input  logic                 latHold,
  input  logic [DW-1:0]        dataIn,
  input  loadStrobe_t          strobe,
  input  logic [NUM_CH/2-1:0]  pairSel,
  output logic [NUM_CH*DW-1:0] colData
);
  logic [DW-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stageQ <= '0;
    else if (strobe.stageEn) stageQ <= dataIn;
  end

  for (genvar p = 0; p < NUM_CH; p++) begin : g_ch
    localparam int PAIR_R = p / 2;
    localparam int PAIR_L = (NUM_CH - 1 - p) / 2;
    localparam bit EVEN   = (p % 2) == 0;
    logic          wrHit, useStage;
    logic [DW-1:0] tempQ, holdQ, nextQ;

    assign wrHit    = strobe.pairWr && (dirRight ? pairSel[PAIR_R] : pairSel[PAIR_L]);
    assign useStage = dirRight ? EVEN : !EVEN;
    assign nextQ    = wrHit ? (useStage ? stageQ : dataIn) : tempQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tempQ <= '0;
        holdQ <= '0;
      end else begin
        tempQ <= nextQ;
        if (!latHold) holdQ <= nextQ;
      end
    end

    assign colData[p*DW +: DW] = latHold ? holdQ : tempQ;
  end
endmodule

// File: rtl/col_token_loader.sv
module col_token_loader
  import col_loader_pkg::*;
#(
  parameter int NUM_CH = 200,
  parameter int DW     = 6,
  parameter int EDGE   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dirRight,
  input  logic                 fullWidth,
  input  logic                 lowEndTokIn,
  input  logic                 highEndTokIn,
  input  logic [DW-1:0]        dataIn,
  input  logic                 latHold,
  output logic                 lowEndTokOut,
  output logic                 highEndTokOut,
  output logic [NUM_CH*DW-1:0] colData
);
  loadStrobe_t           strobe;
  logic [NUM_CH/2-1:0]   pairSel;

  col_loader_ctrl #(.NUM_CH(NUM_CH), .EDGE(EDGE)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullWidth(fullWidth),
    .lowEndTokIn(lowEndTokIn), .highEndTokIn(highEndTokIn),
    .strobe(strobe), .pairSel(pairSel),
    .lowEndTokOut(lowEndTokOut), .highEndTokOut(highEndTokOut)
  );

  col_loader_datapath #(.NUM_CH(NUM_CH), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .latHold(latHold),
    .dataIn(dataIn), .strobe(strobe), .pairSel(pairSel), .colData(colData)
  );
endmodule

// File: rtl/col_token_loader_checker.sv
module col_token_loader_checker
  import col_loader_pkg::*;
#(
  parameter int NUM_CH = 200,
  parameter int DW     = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dirRight,
  input logic                 latHold,
  input logic                 lowEndTokOut,
  input logic                 highEndTokOut,
  input logic [NUM_CH*DW-1:0] colData,
  input loadStrobe_t          strobe,
  input logic [NUM_CH/2-1:0]  pairSel
);
  // R6: the cascade token is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (lowEndTokOut || highEndTokOut) |=> !(lowEndTokOut || highEndTokOut));

  // R7: the entry end never emits a token
  a_r7_quiet_low: assert property (@(posedge clk) disable iff (!rstN)
    dirRight |-> !lowEndTokOut);
  a_r7_quiet_high: assert property (@(posedge clk) disable iff (!rstN)
    !dirRight |-> !highEndTokOut);

  // R9: held output row does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (latHold && $past(latHold)) |-> $stable(colData));

  // R2: at most one pair position holds the token
  a_r2_one_token: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pairSel));

  // R2: every pair write is preceded by staging of its first word
  a_r2_stage_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pairWr |-> $past(strobe.stageEn));
endmodule

bind col_token_loader col_token_loader_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .dirRight(dirRight), .latHold(latHold),
  .lowEndTokOut(lowEndTokOut), .highEndTokOut(highEndTokOut),
  .colData(colData), .strobe(strobe), .pairSel(pairSel)
);

// File: tb/col_token_loader_test.sv
`timescale 1ns/1ps
module col_token_loader_test;
  localparam int N    = 200;
  localparam int DW   = 6;
  localparam int EDGE = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic dirRight = 1'b1, fullWidth = 1'b1, lowIn = 1'b0, highIn = 1'b0, latHold = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic lowOut, highOut;
  logic [N*DW-1:0] colData;

  logic [DW-1:0] expTemp [N];
  logic [DW-1:0] expHold [N];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  col_token_loader #(.NUM_CH(N), .DW(DW), .EDGE(EDGE)) uut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullWidth(fullWidth),
    .lowEndTokIn(lowIn), .highEndTokIn(highIn), .dataIn(dataIn), .latHold(latHold),
    .lowEndTokOut(lowOut), .highEndTokOut(highOut), .colData(colData)
  );

  function automatic int chanOf(bit right, bit full, int k);
    int l = (full ? 0 : EDGE) + k;
    return right ? l : N - 1 - l;
  endfunction

  task automatic checkCols(string req);
    int bad = -1;
    logic [DW-1:0] ex;
    for (int c = 0; c < N; c++) begin
      ex = latHold ? expHold[c] : expTemp[c];
      if (bad < 0 && colData[c*DW +: DW] !== ex) bad = c;
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      ex = latHold ? expHold[bad] : expTemp[bad];
      $display("FAIL %s channel %0d actual %0d expected %0d", req, bad, colData[bad*DW +: DW], ex);
    end
  endtask

  task automatic checkBit(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stopAt > 0: abandon the load after that many cycles (restart case)
  task automatic runLoad(bit right, bit full, int stopAt, string req);
    int m = full ? N : N - 2*EDGE;
    int pulses = 0, seenAt = -1, wrongEnd = 0;
    logic [DW-1:0] w;
    @(negedge clk);
    dirRight = right; fullWidth = full; lowIn = right; highIn = !right;
    dataIn = DW'($urandom);
    for (int i = 1; i <= m + 2; i++) begin
      @(negedge clk);
      if (stopAt > 0 && i > stopAt) return;
      lowIn = 1'b0; highIn = 1'b0;
      if (right ? highOut : lowOut) begin pulses++; seenAt = i; end
      if (right ? lowOut : highOut) wrongEnd++;
      w = DW'($urandom);
      dataIn = w;
      if (i >= 2 && i < 2 + m && stopAt == 0) expTemp[chanOf(right, full, i - 2)] = w;
    end
    if (stopAt > 0) return;
    if (!latHold) for (int c = 0; c < N; c++) expHold[c] = expTemp[c];
    checkCols(req);
    checkBit({req, " R6 pulse count"}, pulses, 1);
    checkBit({req, " R6 pulse position"}, seenAt, m);
    checkBit({req, " R7 entry end quiet"}, wrongEnd, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20031));
    for (int c = 0; c < N; c++) begin expTemp[c] = '0; expHold[c] = '0; end
    repeat (3) @(negedge clk);
    checkCols("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkCols("R1 after reset");
    checkBit("R1 token outs", int'(lowOut) + int'(highOut), 0);

    runLoad(1'b1, 1'b1, 0, "R2 right full");
    runLoad(1'b0, 1'b1, 0, "R3 left full");
    runLoad(1'b1, 1'b0, 0, "R4 right reduced");
    runLoad(1'b0, 1'b0, 0, "R5 left reduced");
    checkCols("R8 transparent row");

    // R9: hold while a new row loads
    @(negedge clk); latHold = 1'b1;
    runLoad(1'b1, 1'b1, 0, "R9 held row");
    @(negedge clk);
    checkCols("R9 still held");
    latHold = 1'b0;
    for (int c = 0; c < N; c++) expHold[c] = expTemp[c];
    #1 checkCols("R8 release shows loaded row");

    // R10: restart mid-load
    runLoad(1'b0, 1'b1, 37, "R10 abandoned");
    runLoad(1'b0, 1'b1, 0, "R10 restarted load");
    runLoad(1'b1, 1'b0, 11, "R10 abandoned reduced");
    runLoad(1'b1, 1'b0, 0, "R10 restarted reduced");

    for (int r = 0; r < 4; r++) begin
      bit rr = 1'($urandom);
      bit ff = 1'($urandom);
      runLoad(rr, ff, 0, rr ? (ff ? "R2 random" : "R4 random") : (ff ? "R3 random" : "R5 random"));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule